// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block derives the periodic interrupt of a real-time clock from a 32.768 kHz tick enable. A 4-bit rate code selects a power-of-two period. The ticks are counted by a free-running counter that starts at zero on reset. An event fires on the tick that brings the counter onto a multiple of the selected period. Because the counter never restarts, event edges always fall on period boundaries, whatever the time at which the block was configured.

Each event can do three things. When the periodic enable is set, it produces a one-cycle pulse that sets the periodic flag bits (mask 0xC0) of the status register, and it asserts a level interrupt request. The request stays high until the status register is read. When the square-wave enable is set, the event also produces a one-cycle pulse on the square-wave output. All pins are plain control and status signals with no data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `pir_rate_gen`

## Requirements
- R1: A rate code of 0 produces no events: `pflag_set`, `irq` and `sqw_pulse` all stay low.
- R2: For an effective code c in the range 3 to 15, events are 2^(c-1) ticks apart. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R3: Codes 1 and 2 have 7 added to them, so they give periods of 128 and 256 ticks.
- R4: An event fires on the tick that brings the count of ticks since reset to a multiple of the period. `pflag_set` is high in the clock cycle that follows that tick's clock edge.
- R5: `pflag_set` is high for exactly one clock cycle per event.
- R6: When `pie_en` is 0, events drive neither `pflag_set` nor `irq`.
- R7: `irq` goes high on an event and stays high until `irq_ack`. If an event and `irq_ack` arrive in the same cycle, the event wins.
- R8: When `sqw_en` is 1, each event produces a one-cycle `sqw_pulse`, whatever the value of `pie_en`. When `sqw_en` is 0, no pulse appears.
- R9: A change of `rate_code` takes effect after the next boundary of the current period. That boundary still fires at the old rate.
- R10: A change of `pie_en` restarts the rate timer: the current `rate_code` is loaded immediately, without waiting for a boundary.
- R11: While `tick_en` is low, the tick count does not advance and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable for each 32.768 kHz tick |
| rate_code | input | 4 | Rate select field from the control register |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| irq_ack | input | 1 | Status-register read strobe that clears `irq` |
| pflag_set | output | 1 | One-cycle pulse that sets the periodic flag bits (0xC0) |
| irq | output | 1 | Interrupt request level |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
The bench builds the block with its default parameters: a 15-bit tick counter, and codes 1 and 2 aliased by adding 7. It mostly drives `tick_en` high on every clock, so one tick takes one clock. That makes even the 16384-tick period of code 15 short enough to measure directly. It also makes the aliased rates, the boundary alignment and the switch from one rate to another reachable within a short run. One scenario gates `tick_en` on alternate cycles to show that the count advances only on ticks.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] rate_code_t;

  // Maps a raw rate code to its effective code; low codes alias to slower rates.
  function automatic rate_code_t pir_remap(input rate_code_t raw, input int alias_max,
                                           input int alias_add);
    if (raw == '0) return '0;
    if (int'(raw) <= alias_max) return rate_code_t'(int'(raw) + alias_add);
    return raw;
  endfunction
endpackage

// File: rtl/pir_tick_counter.sv
module pir_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_inc
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/pir_rate_sel.sv
module pir_rate_sel
  import pir_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_ADD = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rate_code_t       rate_code,
  input  logic             pie_en,
  input  logic             boundary,
  output logic             active,
  output logic [CNT_W-1:0] wrap_mask
);
  rate_code_t eff_q;
  rate_code_t eff_next;
  logic       pie_q;
  logic       reload;

  assign eff_next = pir_remap(rate_code, ALIAS_MAX, ALIAS_ADD);
  assign active   = (eff_q != '0);
  // Reload while idle, at a boundary of the current period, or on an enable change.
  assign reload   = !active || boundary || (pie_en != pie_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q <= '0;
      pie_q <= 1'b0;
    end else begin
      pie_q <= pie_en;
      if (reload) eff_q <= eff_next;
    end
  end

  // Mask of the low (c-1) counter bits that must wrap to zero.
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign wrap_mask[g] = active && (g < (int'(eff_q) - 1));
  end
endmodule

// File: rtl/pir_event_gen.sv
module pir_event_gen #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic [CNT_W-1:0] wrap_mask,
  input  logic             pie_en,
  input  logic             sqw_en,
  input  logic             irq_ack,
  output logic             boundary,
  output logic             pflag_set,
  output logic             irq,
  output logic             sqw_pulse
);
  assign boundary = tick_en && active && ((cnt_inc & wrap_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pflag_set <= 1'b0;
      irq       <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      pflag_set <= boundary && pie_en;
      sqw_pulse <= boundary && sqw_en;
      irq       <= (boundary && pie_en) || (irq && !irq_ack);
    end
  end
endmodule

// File: rtl/pir_rate_gen.sv
module pir_rate_gen
  import pir_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_ADD = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [3:0] rate_code,
  input  logic       pie_en,
  input  logic       sqw_en,
  input  logic       irq_ack,
  output logic       pflag_set,
  output logic       irq,
  output logic       sqw_pulse
);
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] wrap_mask;
  logic             active;
  logic             boundary;

  pir_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_inc(cnt_inc)
  );

  pir_rate_sel #(.CNT_W(CNT_W), .ALIAS_MAX(ALIAS_MAX), .ALIAS_ADD(ALIAS_ADD)) u_sel (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code_t'(rate_code)), .pie_en(pie_en),
    .boundary(boundary), .active(active), .wrap_mask(wrap_mask)
  );

  pir_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .active(active), .cnt_inc(cnt_inc),
    .wrap_mask(wrap_mask), .pie_en(pie_en), .sqw_en(sqw_en), .irq_ack(irq_ack),
    .boundary(boundary), .pflag_set(pflag_set), .irq(irq), .sqw_pulse(sqw_pulse)
  );
endmodule

// File: rtl/pir_rate_gen_chk.sv
module pir_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic pie_en,
  input logic sqw_en,
  input logic irq_ack,
  input logic pflag_set,
  input logic irq,
  input logic sqw_pulse
);
  a_r5_flag_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pflag_set |=> !pflag_set);

  a_r6_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pflag_set) |-> $past(pie_en));

  a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pflag_set |-> irq);

  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  a_r8_sqw_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqw_pulse) |-> $past(sqw_en));

  a_r11_event_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqw_pulse) || $rose(pflag_set) |-> $past(tick_en));
endmodule

bind pir_rate_gen pir_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pie_en(pie_en), .sqw_en(sqw_en),
  .irq_ack(irq_ack), .pflag_set(pflag_set), .irq(irq), .sqw_pulse(sqw_pulse)
);

// File: tb/pir_rate_gen_bench.sv
module pir_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       irq_ack = 1'b0;
  logic       pflag_set, irq, sqw_pulse;
  int         n_chk = 0;
  int         n_bad = 0;
  int         tcount = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  pir_rate_gen u_pir_rate_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code), .pie_en(pie_en),
    .sqw_en(sqw_en), .irq_ack(irq_ack), .pflag_set(pflag_set), .irq(irq),
    .sqw_pulse(sqw_pulse)
  );

  // Ticks seen since reset, advanced on the same edges the design samples.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) tcount <= 0;
    else if (tick_en) tcount <= tcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits on falling edges for a pflag_set pulse; n = cycles waited, -1 on timeout.
  task automatic wait_flag(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (pflag_set) begin n = i; return; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick_en = 1'b0; pie_en = 1'b0; sqw_en = 1'b0; rate_code = 4'd0;
    repeat (3) @(negedge clk);
    check(!pflag_set && !irq && !sqw_pulse, "R1 reset outputs", {pflag_set, irq, sqw_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Selects a code, restarts the timer via the enable, then measures the spacing.
  task automatic t_period(input logic [3:0] code, input int per, input string req);
    int n;
    pie_en = 1'b0; tick_en = 1'b1; rate_code = code;
    @(negedge clk);
    pie_en = 1'b1;
    wait_flag(per + 4, n);
    check(n > 0 && (tcount % per) == 0, {req, " first event aligned"}, tcount % per, 0);
    @(negedge clk);
    check(!pflag_set, "R5 pulse width", pflag_set, 0);
    wait_flag(per + 4, n);
    check(n == per - 1, {req, " period"}, n + 1, per);
  endtask

  task automatic t_code_zero();
    int hits = 0;
    rate_code = 4'd0; pie_en = 1'b0; sqw_en = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    pie_en = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pflag_set || irq || sqw_pulse) hits++;
    end
    check(hits == 0, "R1 code 0 silent", hits, 0);
    sqw_en = 1'b0;
  endtask

  task automatic t_pie_off_sqw();
    int fl = 0, sq = 0;
    rate_code = 4'd3; pie_en = 1'b0; sqw_en = 1'b1; irq_ack = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pflag_set || irq) fl++;
      if (sqw_pulse) begin
        sq++;
        check((tcount % 4) == 0, "R8 sqw aligned", tcount % 4, 0);
      end
    end
    check(fl == 0, "R6 no flag or irq with enable off", fl, 0);
    check(sq == 10, "R8 sqw pulses with enable off", sq, 10);
    sqw_en = 1'b0;
    sq = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sqw_pulse) sq++;
    end
    check(sq == 0, "R8 no sqw when disabled", sq, 0);
  endtask

  task automatic t_irq_hold();
    int n;
    rate_code = 4'd4; pie_en = 1'b0; tick_en = 1'b1;
    @(negedge clk);
    pie_en = 1'b1;
    wait_flag(20, n);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R7 irq held", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq == 1'b0, "R7 irq cleared by ack", irq, 0);
    // Ack in the cycle of the next event edge: the event must win.
    while ((tcount % 8) != 7) @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(pflag_set && irq, "R7 event wins over ack", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_rate_change();
    int n;
    rate_code = 4'd3; pie_en = 1'b0; tick_en = 1'b1;
    @(negedge clk);
    pie_en = 1'b1;
    wait_flag(10, n);
    rate_code = 4'd7;
    wait_flag(10, n);
    check(n == 4, "R9 old rate at next boundary", n, 4);
    wait_flag(80, n);
    check(n > 0 && (tcount % 64) == 0, "R9 new rate aligned", tcount % 64, 0);
    wait_flag(80, n);
    check(n == 64, "R9 new period", n, 64);
  endtask

  task automatic t_restart();
    int n;
    rate_code = 4'd15; pie_en = 1'b0; tick_en = 1'b1;
    @(negedge clk);
    pie_en = 1'b1;
    repeat (20) @(negedge clk);
    rate_code = 4'd3;
    pie_en = 1'b0;
    @(negedge clk);
    pie_en = 1'b1;
    @(negedge clk);
    wait_flag(8, n);
    check(n > 0, "R10 enable change reloads code", n, 5);
  endtask

  task automatic t_gated_ticks();
    int n;
    rate_code = 4'd3; pie_en = 1'b0;
    @(negedge clk);
    pie_en = 1'b1;
    fork
      begin
        for (int i = 0; i < 60; i++) begin tick_en = ~tick_en; @(negedge clk); end
      end
      begin
        wait_flag(30, n);
        wait_flag(30, n);
        check(n == 8, "R11 period doubles with half ticks", n, 8);
      end
    join
    tick_en = 1'b0;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pflag_set) n++;
    end
    check(n == 0, "R11 no event without ticks", n, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_code_zero();
        t_period(4'd3, 4, "R2 code3");
        t_period(4'd6, 32, "R2 code6");
        t_period(4'd15, 16384, "R2 code15");
        t_period(4'd1, 128, "R3 code1");
        t_period(4'd2, 256, "R3 code2");
        t_period(4'd9, 256, "R4 code9");
        t_pie_off_sqw();
        t_irq_hold();
        t_rate_change();
        t_restart();
        t_gated_ticks();
      end
      begin
        while (cyc < 190000) @(negedge clk);
        check(1'b0, "watchdog", cyc, 190000);
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule